// File: doc/BRIEF.md
# Paged receive ring manager

This block places incoming frames into a circular region of local byte memory. The memory is handled in pages of 256 bytes. The ring covers every page from a start page up to the page before a stop page. A host programs the start and stop pages, a boundary page that marks data it has not yet consumed, and a current page where the next frame will land. Frame bytes arrive on a byte stream that marks the first and last byte of each frame and carries two error flags on the last byte. Every accepted byte is written straight to memory through a byte-wide write port.

The first data byte of a frame goes to offset 4 of the current page, and the data runs on through the following pages, wrapping at the stop page. When the last byte has been written and the frame is good, the block fills the four reserved bytes at the head of the frame's first page with a status byte, the page where the next frame will begin, and the stored byte count. It then moves the current page to that next page. A frame that would enter the boundary page is cut off before any byte reaches that page and flags an overwrite. In monitor mode frames are followed but never written. The header takes four cycles, and the source must stay idle during those cycles, because stream beats that arrive while the header is written are dropped.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the host registers at addresses 0 to 6 all read 0, and no memory write happens while reset is held.
- R2: Byte k of a frame (k from 0) is written at page offset k+4, counted from offset 0 of the current page, so that it lands in page (current + (k+4)/256) at offset (k+4) mod 256.
- R3: The page after stop-1 is the start page, for data bytes and for the next-frame page alike.
- R4: For a good frame of length L, offsets 0 to 3 of its first page get, in this order, the status byte 0x01, the next-frame page, (L+4) mod 256 and (L+4)/256, and they are written after the last data byte.
- R5: After a good frame, the current page (address 3) reads current + ceil((L+4)/256) with the wrap of R3 applied.
- R6: A frame whose last byte carries the check-sum error flag or the alignment error flag leaves the current page unchanged, gets no header, and sets the status register (address 5) to 0x02 for the check-sum error and 0x04 for the alignment error (0x06 for both).
- R7: A frame that would write into the boundary page writes no byte there, leaves the current page unchanged, sets event bit 2 (overwrite) and bit 3 (halt state), and sets status 0x10 together with the error bits of R6.
- R8: Event bit 3 clears only when the host writes the boundary register with a value that differs from the one it holds; rewriting the same value leaves it set.
- R9: With control bit 0 (address 4) set, no frame is written to memory, each frame sets status 0x10 plus its error bits, and status bit 6 reads 1 for as long as control bit 0 stays set.
- R10: Event bits 0 (frame stored), 1 (frame dropped) and 2 (overwrite) at address 6 clear when 1 is written to them, and bits written with 0 keep their value.
- R11: Addresses 0 (start page), 1 (stop page), 2 (boundary), 3 (current page) and 4 (control) read back the last value the host wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_bad | input | 1 | Check-sum error, valid with rx_eof |
| rx_align_bad | input | 1 | Alignment error, valid with rx_eof |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | PAGE_W+8 | Memory byte address, page in the upper bits |
| mem_wdata | output | 8 | Memory write byte |
| host_we | input | 1 | Host register write |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |

## Verification
Short frames that stay in one page show the offset-4 placement and the header layout. A frame of exactly 252 bytes against one of 253 bytes shows whether the page count rounds at the 256-byte edge. Frames that start on the last ring page, or that end exactly at it, show whether the data and the next-frame page wrap to the start page. A boundary placed on the second or third page of a long frame, or on the current page itself, shows overrun detection in the middle of a frame and at its first byte. Monitor-mode and errored frames show which outcomes leave the current page alone. Random lengths from 1 to 600 bytes, with a random boundary and random error flags, then mix all of these cases.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_crc_bad,
  input  logic              rx_align_bad,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata
);

  localparam int CNT_W = 16;
  localparam logic [7:0] HDR_OFF = 8'd4;
  localparam logic [7:0] ST_GOOD = 8'h01;
  localparam logic [7:0] ST_MISS = 8'h10;
  localparam logic [2:0] A_START = 3'd0, A_STOP = 3'd1, A_BND = 3'd2,
                         A_CUR = 3'd3, A_CTL = 3'd4, A_STAT = 3'd5, A_EV = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_DROP, S_HDR} st_t;

  st_t              st;
  logic [PAGE_W-1:0] pg_start, pg_stop, pg_bnd, pg_cur;
  logic [PAGE_W-1:0] wr_page, frm_page, nxt_page;
  logic [7:0]        wr_off, last_st;
  logic [CNT_W-1:0]  byte_cnt;
  logic [1:0]        hdr_idx;
  logic              mon, ev_ok, ev_drop, ev_ovw, rst_state;

  function automatic logic [PAGE_W-1:0] wrap_inc(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] s,
                                                 input logic [PAGE_W-1:0] e);
    logic [PAGE_W-1:0] n;
    n = p + 1'b1;
    return (n == e) ? s : n;
  endfunction

  logic              take_new, wbeat, hit, bad;
  logic [PAGE_W-1:0] tgt_page;
  logic [7:0]        tgt_off, errbits, hdr_byte;
  logic [CNT_W-1:0]  frame_len, cnt4;

  assign take_new  = rx_valid && rx_sof && st == S_IDLE && !mon;
  assign wbeat     = take_new || (rx_valid && st == S_DATA);
  assign tgt_page  = take_new ? pg_cur : wr_page;
  assign tgt_off   = take_new ? HDR_OFF : wr_off;
  assign hit       = wbeat && tgt_page == pg_bnd && (take_new || tgt_off == 8'd0);
  assign frame_len = (take_new ? '0 : byte_cnt) + 1'b1;
  assign bad       = rx_crc_bad || rx_align_bad;
  assign errbits   = {5'd0, rx_align_bad, rx_crc_bad, 1'b0};
  assign cnt4      = byte_cnt + CNT_W'(4);

  always_comb begin
    unique case (hdr_idx)
      2'd0: hdr_byte = ST_GOOD;
      2'd1: hdr_byte = 8'(nxt_page);
      2'd2: hdr_byte = cnt4[7:0];
      default: hdr_byte = cnt4[15:8];
    endcase
  end

  assign mem_we    = (wbeat && !hit) || st == S_HDR;
  assign mem_addr  = (st == S_HDR) ? {frm_page, 6'd0, hdr_idx} : {tgt_page, tgt_off};
  assign mem_wdata = (st == S_HDR) ? hdr_byte : rx_data;

  always_comb begin
    unique case (host_addr)
      A_START: host_rdata = 8'(pg_start);
      A_STOP:  host_rdata = 8'(pg_stop);
      A_BND:   host_rdata = 8'(pg_bnd);
      A_CUR:   host_rdata = 8'(pg_cur);
      A_CTL:   host_rdata = {7'd0, mon};
      A_STAT:  host_rdata = {last_st[7], mon, last_st[5:0]};
      A_EV:    host_rdata = {4'd0, rst_state, ev_ovw, ev_drop, ev_ok};
      default: host_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pg_start <= '0; pg_stop <= '0; pg_bnd <= '0; pg_cur <= '0;
      wr_page <= '0; frm_page <= '0; nxt_page <= '0;
      wr_off <= '0; last_st <= '0; byte_cnt <= '0; hdr_idx <= '0;
      mon <= 1'b0; ev_ok <= 1'b0; ev_drop <= 1'b0; ev_ovw <= 1'b0; rst_state <= 1'b0;
    end else begin
      if (host_we) begin
        unique case (host_addr)
          A_START: pg_start <= host_wdata[PAGE_W-1:0];
          A_STOP:  pg_stop  <= host_wdata[PAGE_W-1:0];
          A_BND: begin
            if (host_wdata[PAGE_W-1:0] != pg_bnd) rst_state <= 1'b0;
            pg_bnd <= host_wdata[PAGE_W-1:0];
          end
          A_CUR:   pg_cur <= host_wdata[PAGE_W-1:0];
          A_CTL:   mon <= host_wdata[0];
          A_EV: begin
            ev_ok   <= ev_ok   & ~host_wdata[0];
            ev_drop <= ev_drop & ~host_wdata[1];
            ev_ovw  <= ev_ovw  & ~host_wdata[2];
          end
          default: ;
        endcase
      end

      unique case (st)
        S_IDLE, S_DATA: begin
          if (rx_valid && (st == S_DATA || rx_sof)) begin
            if (hit || (st == S_IDLE && mon)) begin
              if (hit) begin
                ev_ovw    <= 1'b1;
                rst_state <= 1'b1;
              end
              if (rx_eof) begin
                last_st <= ST_MISS | errbits;
                ev_drop <= 1'b1;
                st      <= S_IDLE;
              end else begin
                st <= S_DROP;
              end
            end else begin
              if (st == S_IDLE) frm_page <= pg_cur;
              byte_cnt <= frame_len;
              wr_off   <= tgt_off + 8'd1;
              wr_page  <= (tgt_off == 8'hFF) ? wrap_inc(tgt_page, pg_start, pg_stop) : tgt_page;
              if (rx_eof) begin
                if (bad) begin
                  last_st <= errbits;
                  ev_drop <= 1'b1;
                  st      <= S_IDLE;
                end else begin
                  last_st  <= ST_GOOD;
                  nxt_page <= wrap_inc(tgt_page, pg_start, pg_stop);
                  hdr_idx  <= 2'd0;
                  st       <= S_HDR;
                end
              end else begin
                st <= S_DATA;
              end
            end
          end
        end
        S_DROP: begin
          if (rx_valid && rx_eof) begin
            last_st <= ST_MISS | errbits;
            ev_drop <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: begin
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) begin
            pg_cur <= nxt_page;
            ev_ok  <= 1'b1;
            st     <= S_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [PAGE_W+7:0] mem_addr,
  input logic [PAGE_W-1:0] pg_start,
  input logic [PAGE_W-1:0] pg_stop,
  input logic [PAGE_W-1:0] pg_bnd,
  input logic [PAGE_W-1:0] pg_cur,
  input logic              mon,
  input logic              st_idle,
  input logic              ev_ovw,
  input logic              rst_state,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic              hdr_done
);

  p_no_bnd_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[PAGE_W+7:8] != pg_bnd);

  p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PAGE_W+7:8] >= pg_start && mem_addr[PAGE_W+7:8] < pg_stop));

  p_mon_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && mon) |-> !mem_we);

  p_ovw_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ovw) |-> rst_state);

  p_cur_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pg_cur) |-> $past(hdr_done || (host_we && host_addr == 3'd3)));

endmodule

bind rx_page_ring rx_page_ring_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .pg_start(pg_start), .pg_stop(pg_stop), .pg_bnd(pg_bnd), .pg_cur(pg_cur),
  .mon(mon), .st_idle(st == S_IDLE), .ev_ovw(ev_ovw), .rst_state(rst_state),
  .host_we(host_we), .host_addr(host_addr), .hdr_done(st == S_HDR && hdr_idx == 2'd3)
);

// File: tb/sim_rx_page_ring.sv
module sim_rx_page_ring;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, rx_valid, rx_sof, rx_eof, rx_crc_bad, rx_align_bad;
  logic [7:0]    rx_data, host_wdata, host_rdata, mem_wdata;
  logic          host_we, mem_we;
  logic [2:0]    host_addr;
  logic [PW+7:0] mem_addr;

  rx_page_ring #(.PAGE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mem [int];
  logic [7:0] fdat [0:2047];
  int bnd_hits, out_hits, wr_count;
  int m_start, m_stop, m_bnd, m_cur;
  bit m_rst, m_mon;

  always begin
    @(negedge clk);
    #3;
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_count++;
      if (int'(mem_addr[PW+7:8]) == m_bnd) bnd_hits++;
      if (int'(mem_addr[PW+7:8]) < m_start || int'(mem_addr[PW+7:8]) >= m_stop) out_hits++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 3'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input int a, output int v);
    @(negedge clk);
    host_addr = 3'(a);
    #1;
    v = int'(host_rdata);
  endtask

  function automatic int adv(input int p, input int n);
    for (int i = 0; i < n; i++) p = (p + 1 == m_stop) ? m_start : p + 1;
    return p;
  endfunction

  function automatic int mget(input int a);
    if (mem.exists(a)) return int'(mem[a]);
    return -1;
  endfunction

  task automatic send(input int len, input bit crc, input bit aln);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fdat[k];
      rx_sof = (k == 0); rx_eof = (k == len - 1);
      rx_crc_bad = crc && (k == len - 1);
      rx_align_bad = aln && (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_bad = 1'b0; rx_align_bad = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input string tag, input int len, input bit crc, input bit aln);
    int n, errs, exp_st, exp_ev, nxt, v, miss;
    bit ovr;
    for (int k = 0; k < len; k++) fdat[k] = 8'($urandom);
    hwr(6, 8'h07);
    bnd_hits = 0; out_hits = 0; wr_count = 0;
    n = (len + 4 + 255) / 256;
    ovr = 0;
    if (!m_mon) for (int i = 0; i < n; i++) if (adv(m_cur, i) == m_bnd) ovr = 1;
    errs = (crc ? 2 : 0) | (aln ? 4 : 0);
    send(len, crc, aln);
    if (m_mon) begin
      exp_st = 8'h50 | errs;
      exp_ev = 2 | (m_rst ? 8 : 0);
      chk({tag, " monitor writes"}, wr_count, 0);
    end else if (ovr) begin
      m_rst = 1;
      exp_st = 8'h10 | errs;
      exp_ev = 2 | 4 | 8;
      chk({tag, " boundary page writes"}, bnd_hits, 0);
    end else if (errs != 0) begin
      exp_st = errs;
      exp_ev = 2 | (m_rst ? 8 : 0);
    end else begin
      exp_st = 1;
      exp_ev = 1 | (m_rst ? 8 : 0);
      nxt = adv(m_cur, n);
      chk({tag, " hdr status"}, mget(m_cur * 256 + 0), 1);
      chk({tag, " hdr next"}, mget(m_cur * 256 + 1), nxt);
      chk({tag, " hdr cnt lo"}, mget(m_cur * 256 + 2), (len + 4) & 255);
      chk({tag, " hdr cnt hi"}, mget(m_cur * 256 + 3), (len + 4) >> 8);
      miss = 0;
      for (int k = 0; k < len; k++)
        if (mget(adv(m_cur, (k + 4) >> 8) * 256 + ((k + 4) & 255)) != int'(fdat[k])) miss++;
      chk({tag, " data bytes"}, miss, 0);
      m_cur = nxt;
    end
    hrd(3, v); chk({tag, " current page"}, v, m_cur);
    hrd(5, v); chk({tag, " status"}, v, exp_st);
    hrd(6, v); chk({tag, " events"}, v, exp_ev);
    chk({tag, " writes outside ring"}, out_hits, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    m_start = 0; m_stop = 0; m_bnd = 0; m_cur = 0; m_rst = 0; m_mon = 0;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'd0; rx_sof = 1'b0; rx_eof = 1'b0;
    rx_crc_bad = 1'b0; rx_align_bad = 1'b0; host_we = 1'b0; host_addr = 3'd0; host_wdata = 8'd0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 write during reset", int'(mem_we), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) begin
      hrd(a, v);
      chk("R1 reset register", v, 0);
    end

    m_start = 8'h40; m_stop = 8'h60; m_bnd = 8'h40; m_cur = 8'h41;
    hwr(0, m_start); hwr(1, m_stop); hwr(2, m_bnd); hwr(3, m_cur); hwr(4, 0);
    hrd(0, v); chk("R11 start", v, 8'h40);
    hrd(1, v); chk("R11 stop", v, 8'h60);
    hrd(2, v); chk("R11 boundary", v, 8'h40);
    hrd(3, v); chk("R11 current", v, 8'h41);
    hrd(4, v); chk("R11 control", v, 0);

    run_frame("R2 R4 R5 short", 60, 0, 0);
    run_frame("R5 exactly one page", 252, 0, 0);
    run_frame("R5 just over one page", 253, 0, 0);

    hwr(2, 8'h50); m_bnd = 8'h50;
    hwr(3, 8'h5F); m_cur = 8'h5F;
    run_frame("R3 data wrap", 300, 0, 0);
    hwr(3, 8'h5E); m_cur = 8'h5E;
    run_frame("R3 next page wrap", 508, 0, 0);

    run_frame("R6 crc error", 100, 1, 0);
    run_frame("R6 align error", 80, 0, 1);

    hwr(3, 8'h4E); m_cur = 8'h4E;
    run_frame("R7 mid-frame overrun", 700, 0, 0);
    hwr(2, 8'h50);
    hrd(6, v); chk("R8 same boundary keeps halt", v & 8, 8);
    hwr(2, 8'h52); m_bnd = 8'h52; m_rst = 0;
    hrd(6, v); chk("R8 advanced boundary clears halt", v & 8, 0);
    hwr(3, 8'h52); m_cur = 8'h52;
    run_frame("R7 overrun at first byte", 1, 0, 0);
    hwr(2, 8'h4A); m_bnd = 8'h4A; m_rst = 0;

    hwr(4, 1); m_mon = 1;
    hrd(5, v); chk("R9 disabled bit live", v & 8'h40, 8'h40);
    run_frame("R9 monitor frame", 120, 1, 0);
    hwr(4, 0); m_mon = 0;
    hrd(5, v); chk("R9 disabled bit cleared", v, 8'h12);

    hwr(6, 0);
    hrd(6, v); chk("R10 write zero keeps", v, 2);
    hwr(6, 1);
    hrd(6, v); chk("R10 other bit keeps", v, 2);
    hwr(6, 2);
    hrd(6, v); chk("R10 write one clears", v, 0);

    for (int it = 0; it < 40; it++) begin
      int nb, len, e;
      nb = 8'h40 + $urandom_range(0, 31);
      hwr(2, nb);
      if (nb != m_bnd) m_rst = 0;
      m_bnd = nb;
      len = $urandom_range(1, 600);
      e = $urandom_range(0, 7);
      run_frame("R2 R5 R6 R7 random", len, e == 0, e == 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule